// File: doc/BRIEF.md
# Double-Buffered Bidirectional I/O Port

This block is a single 32-channel static digital I/O port whose channels are each set to drive or to listen on their own. Software first stages an output value and a direction mask in two first-stage latches, each loaded by its own write strobe. A commit strobe is shared by every port in the system. It moves both staged words into the second-stage registers in one cycle, so several ports instantiated side by side change their pins together.

On the input side, the pins pass through a synchronizer. A capture strobe, also shared across ports, freezes the synchronized levels into a sample register that holds until the next capture. All five stored words can be read back through a select input: the two staged words, the two committed words and the sample. Software can compare a sampled bit with the committed direction bit and so tell whether the level came from this port or from the external unit under test. Address decoding stays outside the block.

Top module: `dbio_port`

## Requirements
- R1: While `rstN` is low, every stored word is zero. All channels are then high impedance (`pinOe` = 0) and every read selection returns zero.
- R2: `dataWr` loads `wrData` into the staged data word, and `dirWr` loads `wrData` into the staged direction word. Each strobe leaves the other staged word untouched.
- R3: `updateStb` copies both staged words into the committed data and direction words on the same clock edge. Without it, `pinOut` and `pinOe` hold their values, whatever the staged words do.
- R4: `pinOut` carries the committed data word and `pinOe` the committed direction word. A direction bit of 1 drives that channel, and a bit of 0 leaves it high impedance.
- R5: Each pin passes through a two-flop synchronizer. A `sampleStb` at clock edge k stores the `pinIn` value that was present at edge k-2, and the sample holds until the next `sampleStb`.
- R6: When a staged write and `updateStb` fall in the same cycle, the committed word takes the staged value from before that write. The new value reaches the pins only on a later update.
- R7: `rdData` shows the word picked by `rdSel`: 0 is the staged data, 1 the staged direction, 2 the committed data, 3 the committed direction and 4 the sample. Codes 5 to 7 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrData | input | 32 | Write data for the staged words |
| dataWr | input | 1 | Port-specific strobe: load staged data |
| dirWr | input | 1 | Port-specific strobe: load staged direction |
| updateStb | input | 1 | Shared strobe: commit staged words to pins |
| sampleStb | input | 1 | Shared strobe: capture synchronized pins |
| rdSel | input | 3 | Readback selection code |
| rdData | output | 32 | Selected readback word |
| pinIn | input | 32 | Pin levels seen from outside |
| pinOut | output | 32 | Committed output levels |
| pinOe | output | 32 | Committed per-channel output enables |

## Verification
The hardest case to reach is a staged write that lands in the same cycle as the commit strobe, because the design must commit the old word rather than the one being written. The stimulus forces that collision with directed writes of distinct words, and random stimulus produces further collisions as strobes overlap. The two-cycle capture lag only shows when the pins change every cycle around a capture. The bench therefore drives a fresh pin word on each clock and keeps a history of pin words to predict which one lands in the sample.

// File: rtl/dbio_pkg.sv
`timescale 1ns/1ps
package dbio_pkg;

  typedef struct packed {
    logic loadData;
    logic loadDir;
    logic commit;
    logic capture;
  } strobe_t;

  typedef enum logic [2:0] {
    VIEW_DATA_STAGE = 3'd0,
    VIEW_DIR_STAGE  = 3'd1,
    VIEW_DATA_OUT   = 3'd2,
    VIEW_DIR_OUT    = 3'd3,
    VIEW_SAMPLE     = 3'd4
  } view_e;

  localparam int NUM_VIEWS = 5;
  localparam int SEL_W     = 3;

endpackage

// File: rtl/dbio_ctrl.sv
`timescale 1ns/1ps
module dbio_ctrl
  import dbio_pkg::*;
(
  input  logic                 dataWr,
  input  logic                 dirWr,
  input  logic                 updateStb,
  input  logic                 sampleStb,
  input  logic [SEL_W-1:0]     rdSel,
  output strobe_t              stb,
  output logic [NUM_VIEWS-1:0] viewHot
);

  always_comb begin
    stb.loadData = dataWr;
    stb.loadDir  = dirWr;
    stb.commit   = updateStb;
    stb.capture  = sampleStb;
  end

  // One select line per readable word; unused codes select nothing (R7)
  for (genvar v = 0; v < NUM_VIEWS; v++) begin : g_view
    assign viewHot[v] = (rdSel == SEL_W'(v));
  end

endmodule

// File: rtl/dbio_dp.sv
`timescale 1ns/1ps
module dbio_dp
  import dbio_pkg::*;
#(
  parameter int CHAN_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [NUM_VIEWS-1:0] viewHot,
  input  logic [CHAN_W-1:0]    wrData,
  input  logic [CHAN_W-1:0]    pinIn,
  output logic [CHAN_W-1:0]    pinOut,
  output logic [CHAN_W-1:0]    pinOe,
  output logic [CHAN_W-1:0]    rdData
);

  localparam int LAST_SYNC = SYNC_STAGES - 1;

  logic [CHAN_W-1:0] dataStage, dirStage, dataOut, dirOut, sampleReg;
  logic [CHAN_W-1:0] syncChain [SYNC_STAGES];
  logic [CHAN_W-1:0] views [NUM_VIEWS];

  // First stage: independent staged words (R2)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataStage <= '0;
      dirStage  <= '0;
    end else begin
      if (stb.loadData) dataStage <= wrData;
      if (stb.loadDir)  dirStage  <= wrData;
    end
  end

  // Second stage: joint commit, old staged value on collision (R3, R6)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
      dirOut  <= '0;
    end else if (stb.commit) begin
      dataOut <= dataStage;
      dirOut  <= dirStage;
    end
  end

  assign pinOut = dataOut;
  assign pinOe  = dirOut;

  // Input synchronizer (R5)
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[0] <= '0;
        else       syncChain[0] <= pinIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[s] <= '0;
        else       syncChain[s] <= syncChain[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            sampleReg <= '0;
    else if (stb.capture) sampleReg <= syncChain[LAST_SYNC];
  end

  // Readback (R7)
  always_comb begin
    views[VIEW_DATA_STAGE] = dataStage;
    views[VIEW_DIR_STAGE]  = dirStage;
    views[VIEW_DATA_OUT]   = dataOut;
    views[VIEW_DIR_OUT]    = dirOut;
    views[VIEW_SAMPLE]     = sampleReg;
    rdData = '0;
    for (int v = 0; v < NUM_VIEWS; v++)
      rdData = rdData | (views[v] & {CHAN_W{viewHot[v]}});
  end

  p_load_data_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadData |=> dataStage == $past(wrData));

  p_load_dir_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadDir |=> dirStage == $past(wrData));

  p_commit_pair_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> (pinOut == $past(dataStage)) && (pinOe == $past(dirStage)));

  p_pins_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> $stable(pinOut) && $stable(pinOe));

  p_sample_from_sync_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> sampleReg == $past(syncChain[LAST_SYNC]));

  p_sample_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capture |=> $stable(sampleReg));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |-> (pinOe == '0) && (rdData == '0));

endmodule

// File: rtl/dbio_port.sv
`timescale 1ns/1ps
module dbio_port
  import dbio_pkg::*;
#(
  parameter int CHAN_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CHAN_W-1:0] wrData,
  input  logic              dataWr,
  input  logic              dirWr,
  input  logic              updateStb,
  input  logic              sampleStb,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [CHAN_W-1:0] rdData,
  input  logic [CHAN_W-1:0] pinIn,
  output logic [CHAN_W-1:0] pinOut,
  output logic [CHAN_W-1:0] pinOe
);

  strobe_t              stb;
  logic [NUM_VIEWS-1:0] viewHot;

  dbio_ctrl u_ctrl (
    .dataWr    (dataWr),
    .dirWr     (dirWr),
    .updateStb (updateStb),
    .sampleStb (sampleStb),
    .rdSel     (rdSel),
    .stb       (stb),
    .viewHot   (viewHot)
  );

  dbio_dp #(.CHAN_W(CHAN_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .viewHot (viewHot),
    .wrData  (wrData),
    .pinIn   (pinIn),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .rdData  (rdData)
  );

endmodule

// File: tb/sim_dbio_port.sv
`timescale 1ns/1ps
module sim_dbio_port;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] wrData = '0, pinIn = '0;
  logic        dataWr = 0, dirWr = 0, updateStb = 0, sampleStb = 0;
  logic [2:0]  rdSel = '0;
  logic [31:0] rdData, pinOut, pinOe;

  int nRun = 0, nFail = 0;

  // reference model state
  logic [31:0] mDataStage = '0, mDirStage = '0, mDataOut = '0, mDirOut = '0, mSample = '0;
  logic [31:0] hist[$];

  always #4 clk = ~clk;

  dbio_port u0 (
    .clk(clk), .rstN(rstN), .wrData(wrData), .dataWr(dataWr), .dirWr(dirWr),
    .updateStb(updateStb), .sampleStb(sampleStb), .rdSel(rdSel), .rdData(rdData),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [31:0] e;
    string tag;
    chk("R4 pinOut", pinOut, mDataOut);
    chk("R4 pinOe", pinOe, mDirOut);
    for (int s = 0; s < 8; s++) begin
      rdSel = 3'(s);
      #0.3;
      case (s)
        0: begin e = mDataStage; tag = "R2 staged data"; end
        1: begin e = mDirStage;  tag = "R2 staged dir"; end
        2: begin e = mDataOut;   tag = "R3 committed data"; end
        3: begin e = mDirOut;    tag = "R3 committed dir"; end
        4: begin e = mSample;    tag = "R5 sample"; end
        default: begin e = '0;   tag = "R7 unused code"; end
      endcase
      chk(tag, rdData, e);
    end
  endtask

  task automatic tick(input logic dw, input logic iw, input logic up, input logic sm,
                      input logic [31:0] wd, input logic [31:0] pin);
    dataWr = dw; dirWr = iw; updateStb = up; sampleStb = sm; wrData = wd; pinIn = pin;
    @(posedge clk); #1;
    if (sm) mSample = hist[0];
    hist.push_back(pin);
    void'(hist.pop_front());
    if (up) begin mDataOut = mDataStage; mDirOut = mDirStage; end
    if (dw) mDataStage = wd;
    if (iw) mDirStage = wd;
    @(negedge clk);
    compareAll();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rstN = 1'b0;
    hist.push_back('0);
    hist.push_back('0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 pinOe", pinOe, '0);
    compareAll();
    rstN = 1'b1;

    // R2: data write alone, pins unchanged (R3 hold)
    tick(1, 0, 0, 0, 32'hA5A5_0F0F, 32'h0);
    chk("R3 pins held", pinOut, 32'h0);
    // R2: direction write alone
    tick(0, 1, 0, 0, 32'hFFFF_0000, 32'h0);
    chk("R2 data kept", mDataStage, 32'hA5A5_0F0F);
    // R3/R4: commit
    tick(0, 0, 1, 0, 32'h0, 32'h0);
    chk("R4 drive enables", pinOe, 32'hFFFF_0000);
    chk("R3 pinOut", pinOut, 32'hA5A5_0F0F);

    // R6: write collides with commit
    tick(1, 1, 1, 0, 32'h1234_5678, 32'h0);
    chk("R6 old data committed", pinOut, 32'hA5A5_0F0F);
    chk("R6 old dir committed", pinOe, 32'hFFFF_0000);
    tick(0, 0, 1, 0, 32'h0, 32'h0);
    chk("R6 new data later", pinOut, 32'h1234_5678);

    // R5: pins change each cycle, capture lag
    tick(0, 0, 0, 0, 32'h0, 32'h1111_1111);
    tick(0, 0, 0, 0, 32'h0, 32'h2222_2222);
    tick(0, 0, 0, 1, 32'h0, 32'h3333_3333);
    rdSel = 3'd4; #0.3;
    chk("R5 lag two cycles", rdData, 32'h1111_1111);
    tick(0, 0, 0, 0, 32'h0, 32'h4444_4444);
    rdSel = 3'd4; #0.3;
    chk("R5 sample held", rdData, 32'h1111_1111);

    // random traffic
    for (int i = 0; i < 2000; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      tick(r[0], r[1], r[2] & r[3], ($urandom % 3) == 0, $urandom, $urandom);
    end
    summary();
  end

endmodule